// File: doc/BRIEF.md
# Self-Correcting One-Hot Ring Counter

This block keeps a single asserted bit circulating through a WIDTH-bit register and moves it one place toward the least significant end on every enabled clock. When it leaves bit 0, the bit comes back in at the top. The output is a set of WIDTH non-overlapping phase strobes. A counter, sequencer or time-slot selector can use these strobes directly, with no decoder.

The serial input at the top of the register is produced from the register's own contents. A one is fed in only when every bit above bit 0 is clear, and a zero is fed in otherwise. As a result, any pattern the register may hold drains into the one-hot loop within WIDTH enabled clocks: several ones, no ones, or a pattern caused by an upset. Correct operation therefore does not depend on a seeded value. The asynchronous power-on reset loads a start pattern, which is the top bit alone unless the INIT_PATTERN parameter chooses another value. The reset takes no part in counting. A synchronous enable freezes the register without touching the clock. WIDTH must be at least 2, and an elaboration error enforces this.

Top module: `ring_counter_sc`

## Requirements
- R1: While por_n is low the output equals INIT_PATTERN; the default INIT_PATTERN is the most significant bit alone (1000 for WIDTH=4).
- R2: From a one-hot state with en high, each clock moves the one from bit k to bit k-1, and bit 0 wraps to bit WIDTH-1: 1000, 0100, 0010, 0001, 1000.
- R3: In the legal loop, WIDTH consecutive enabled clocks visit WIDTH distinct one-hot patterns and then return to the starting pattern.
- R4: On each enabled clock, bit i takes the old value of bit i+1 for i below WIDTH-1, and bit WIDTH-1 becomes 1 exactly when old bits WIDTH-1 down to 1 are all zero.
- R5: From any starting pattern, including all zeros and patterns with several ones, the output holds exactly one set bit after at most WIDTH enabled clocks.
- R6: Once the output is one-hot it stays one-hot on every later clock, whether or not it is enabled.
- R7: While en is low the output keeps its value on every clock, legal or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| en | input | 1 | Synchronous advance enable |
| phase | output | WIDTH | One-hot phase state |

## Verification
Recovery from an illegal pattern and the enable hold can occur in the same cycle. When en drops while the register holds several ones or none, the hold must win, and the illegal pattern must stay frozen rather than repair itself. To provoke this, the bench starts sixteen copies from every 4-bit pattern and applies the enable to each copy separately, both in directed runs and at random. A bench model decides every clock whether a shift or a hold was due. Recovery is judged by counting only enabled edges, never elapsed cycles.

// File: rtl/ring_sc_pkg.sv
package ring_sc_pkg;
  localparam int MAXW = 64;

  // 1 when every bit from index 1 up to w-1 is clear
  function automatic logic upper_clear(input logic [MAXW-1:0] s, input int w);
    logic any;
    any = 1'b0;
    for (int i = 1; i < MAXW; i++)
      if (i < w) any = any | s[i];
    return !any;
  endfunction

  // number of set bits among the low w bits
  function automatic int ones_in(input logic [MAXW-1:0] s, input int w);
    int n;
    n = 0;
    for (int i = 0; i < MAXW; i++)
      if (i < w && s[i]) n++;
    return n;
  endfunction
endpackage

// File: rtl/ring_feedback.sv
module ring_feedback #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  output logic             fb
);
  import ring_sc_pkg::*;
  logic [MAXW-1:0] q_ext;
  assign q_ext = MAXW'(q);
  assign fb    = upper_clear(q_ext, WIDTH);
endmodule

// File: rtl/ring_shift_reg.sv
module ring_shift_reg #(
  parameter int               WIDTH        = 4,
  parameter logic [WIDTH-1:0] INIT_PATTERN = {1'b1, {(WIDTH-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             en,
  input  logic             fb,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] d;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    if (i == WIDTH - 1) begin : g_top
      assign d[i] = fb;
    end else begin : g_low
      assign d[i] = q[i+1];
    end
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)  q[i] <= INIT_PATTERN[i];
      else if (en) q[i] <= d[i];
    end
  end

  // R7: disabled clocks leave the register untouched
  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!por_n)
    !en |=> $stable(q));
endmodule

// File: rtl/ring_legal_watch.sv
module ring_legal_watch #(
  parameter int WIDTH = 4
) (
  input  logic                       clk,
  input  logic                       por_n,
  input  logic                       en,
  input  logic [WIDTH-1:0]           q,
  output logic                       legal,
  output logic [$clog2(WIDTH+1)-1:0] rcv_cnt
);
  import ring_sc_pkg::*;
  localparam int CW = $clog2(WIDTH + 1);
  localparam logic [CW-1:0] CMAX = CW'(WIDTH);

  logic [MAXW-1:0] q_ext;
  assign q_ext = MAXW'(q);
  assign legal = (ones_in(q_ext, WIDTH) == 1);

  // enabled edges spent while the pattern was illegal
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                            rcv_cnt <= '0;
    else if (legal)                        rcv_cnt <= '0;
    else if (en && rcv_cnt != CMAX)        rcv_cnt <= rcv_cnt + 1'b1;
  end

  // R6: the one-hot loop is closed
  p_legal_stays_r6: assert property (@(posedge clk) disable iff (!por_n)
    legal |=> legal);
  // R5: an illegal pattern never survives WIDTH enabled edges
  p_recover_bound_r5: assert property (@(posedge clk) disable iff (!por_n)
    !legal |-> (rcv_cnt < CMAX));
endmodule

// File: rtl/ring_counter_sc.sv
module ring_counter_sc #(
  parameter int               WIDTH        = 4,
  parameter logic [WIDTH-1:0] INIT_PATTERN = {1'b1, {(WIDTH-1){1'b0}}}
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             en,
  output logic [WIDTH-1:0] phase
);
  localparam int CW = $clog2(WIDTH + 1);

  if (WIDTH < 2 || WIDTH > ring_sc_pkg::MAXW) begin : g_bad_width
    $error("ring_counter_sc: WIDTH out of range");
  end

  logic          feed_bit;
  logic          legal;
  logic [CW-1:0] rcv_cnt;

  ring_feedback #(.WIDTH(WIDTH)) u_fb (
    .q  (phase),
    .fb (feed_bit)
  );

  ring_shift_reg #(.WIDTH(WIDTH), .INIT_PATTERN(INIT_PATTERN)) u_reg (
    .clk   (clk),
    .por_n (por_n),
    .en    (en),
    .fb    (feed_bit),
    .q     (phase)
  );

  ring_legal_watch #(.WIDTH(WIDTH)) u_watch (
    .clk     (clk),
    .por_n   (por_n),
    .en      (en),
    .q       (phase),
    .legal   (legal),
    .rcv_cnt (rcv_cnt)
  );

  // R4: lower bits take the old neighbour above
  p_shift_low_r4: assert property (@(posedge clk) disable iff (!por_n)
    en |=> phase[WIDTH-2:0] == $past(phase[WIDTH-1:1]));
  // R4: top bit set only when all old upper bits were clear
  p_feed_top_r4: assert property (@(posedge clk) disable iff (!por_n)
    en |=> phase[WIDTH-1] == ($past(phase[WIDTH-1:1]) == '0));
  // R2: a legal state rotates with wrap from bit 0 to the top
  p_rotate_r2: assert property (@(posedge clk) disable iff (!por_n)
    (en && legal) |=> phase == {$past(phase[0]), $past(phase[WIDTH-1:1])});
endmodule

// File: tb/test_ring_counter_sc.sv
module test_ring_counter_sc;
  localparam int W = 4;
  localparam int NS = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic en_d = 1'b0;
  logic [NS-1:0] en_v = '0;
  logic [W-1:0] ph_d;
  logic [W-1:0] ph [NS];

  always #5 clk = ~clk;

  ring_counter_sc i_ring_counter_sc (.clk(clk), .por_n(por_n), .en(en_d), .phase(ph_d));

  for (genvar s = 0; s < NS; s++) begin : g_any
    ring_counter_sc #(.WIDTH(W), .INIT_PATTERN(4'(s))) i_ring_counter_sc (
      .clk(clk), .por_n(por_n), .en(en_v[s]), .phase(ph[s]));
  end

  int nchk = 0, nerr = 0;
  bit done = 1'b0;
  logic [W-1:0] mdl [NS];
  logic [W-1:0] mdl_d;
  int  edges [NS];
  bit  seen  [NS];

  function automatic logic [W-1:0] b_next(input logic [W-1:0] s);
    logic [W-2:0] up;
    up = s[W-1:1];
    return {(up == '0), up};
  endfunction

  function automatic bit b_onehot(input logic [W-1:0] s);
    int c;
    c = 0;
    for (int i = 0; i < W; i++) c += int'(s[i]);
    return c == 1;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%b expected=%b", req, act[W-1:0], exp[W-1:0]);
    end
  endtask

  task automatic reset_all();
    en_v = '0; en_d = 1'b0; por_n = 1'b0;
    @(negedge clk); @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      chk(ph[i] == 4'(i), "R1 reset pattern", int'(ph[i]), i);
      mdl[i] = 4'(i); edges[i] = 0; seen[i] = b_onehot(4'(i));
    end
    chk(ph_d == 4'b1000, "R1 default reset", int'(ph_d), 8);
    mdl_d = 4'b1000;
    por_n = 1'b1;
  endtask

  task automatic step();
    logic [NS-1:0] e;
    logic ed;
    e = en_v; ed = en_d;
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NS; i++) begin
      if (e[i]) begin
        mdl[i] = b_next(mdl[i]);
        edges[i]++;
        chk(ph[i] == mdl[i], "R4 shift and feed", int'(ph[i]), int'(mdl[i]));
      end else begin
        chk(ph[i] == mdl[i], "R7 hold", int'(ph[i]), int'(mdl[i]));
      end
      if (edges[i] >= W)
        chk(b_onehot(ph[i]), "R5 recovered", int'(ph[i]), int'(mdl[i]));
      if (seen[i])
        chk(b_onehot(ph[i]), "R6 stays legal", int'(ph[i]), int'(mdl[i]));
      if (b_onehot(ph[i])) seen[i] = 1'b1;
    end
    if (ed) mdl_d = b_next(mdl_d);
    chk(ph_d == mdl_d, ed ? "R2 rotate" : "R7 hold", int'(ph_d), int'(mdl_d));
  endtask

  initial begin
    logic [W-1:0] first;
    logic [W-1:0] seenp [W];
    int distinct;
    reset_all();
    // directed: every start pattern, all enabled
    en_v = '1; en_d = 1'b1;
    repeat (W) step();
    for (int i = 0; i < NS; i++)
      chk(b_onehot(ph[i]), "R5 after WIDTH enabled clocks", int'(ph[i]), int'(mdl[i]));
    // R2/R3: one full period on the default copy
    first = ph_d;
    distinct = 0;
    for (int k = 0; k < W; k++) begin
      bit dup;
      dup = 1'b0;
      for (int j = 0; j < k; j++) if (seenp[j] == ph_d) dup = 1'b1;
      if (!dup) distinct++;
      seenp[k] = ph_d;
      chk(ph_d == (first >> k) | (first << (W - k)), "R2 order",
          int'(ph_d), int'((first >> k) | (first << (W - k))));
      step();
    end
    chk(distinct == W, "R3 distinct count", distinct, W);
    chk(ph_d == first, "R3 period return", int'(ph_d), int'(first));
    // hold while illegal: enable low right after reset
    reset_all();
    en_v = '0; en_d = 1'b0;
    repeat (3) step();
    // mixed: some copies enabled, others frozen in illegal patterns
    en_v = 16'hA5A5; en_d = 1'b1;
    repeat (2) step();
    // constrained random enables with fixed seed
    void'($urandom(32'h1234_5678));
    for (int c = 0; c < 400; c++) begin
      for (int i = 0; i < NS; i++) en_v[i] = ($urandom % 4) != 0;
      en_d = ($urandom % 3) != 0;
      step();
    end
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule